// File: doc/BRIEF.md
# Directory DMA request handler

This block is the per-line slice of a coherence directory that serves a DMA engine next to a set of caches. It holds the state of one memory line: invalid, shared by a set of caches, or owned by a single cache, with the other caches possibly still sharing it. It also keeps a bitmask of sharers and the owner's identifier. Requests come in on one port, tagged with a kind and a requester identifier. The slice answers by driving a memory request (read or write), invalidations to sharers, a forward to the owner, and a response (data or acknowledgement) to the requester.

A DMA write that covers the whole line goes straight to memory. A DMA write that covers only part of the line is done as read-modify-write. The old line comes back either from memory or from the owning cache. The slice copies the DMA bytes over the window [offset, offset+length), keeps every other byte as it was, and writes the merged line back to memory. Memory read responses are routed by a tag bit that the slice attaches to each memory read: one path handles cache requesters and the other handles DMA. A DMA engine never sends an unblock after a read, so the slice raises an internal unblock for it. Unblocks only ever add caches to the sharer list.

Every transaction passes through transient states. While the line is in one of them, the request port holds `reqReady` low, so new requests wait at the port until it rises again.

Top module: `dir_dma_slice`

## Requirements
- R1: A DMA write (reqKind 3) is full-line when reqLen equals LINE_BYTES, which requires reqOffset 0. Any other length is a partial write covering bytes reqOffset to reqOffset+reqLen-1.
- R2: A full-line DMA write to an invalid or shared line is answered one cycle after acceptance. The answer is a memory write (memReqWrite 1) of reqData together with an acknowledgement (rspIsAck 1, rspToDma 1) to the requester, whose rspAckCount equals the number of sharers invalidated (zero when the line is invalid). The line then waits for an unblock.
- R3: A partial DMA write to an invalid or shared line issues, one cycle after acceptance, a memory read tagged as DMA (memReqIsDma 1). No response is sent at that point.
- R4: When memory data returns for a partial write, the next cycle carries a memory write of the merged line and the acknowledgement. In the merged line, byte i (bits 8i+7..8i) is taken from the DMA data inside the written window and from the returned line everywhere else.
- R5: A DMA write to a shared line sends invalidValid with invMask equal to the sharer bitmask, one bit per cache identifier, and then empties the sharer list.
- R6: A DMA read (reqKind 2) of an invalid or shared line issues a DMA-tagged memory read. The returned data goes to the DMA requester in the next cycle, and the line returns to its stable state one cycle later without any further input. The DMA requester is never added to the sharers.
- R7: A cache read-shared request (reqKind 0) on an invalid or shared line issues a cache-tagged memory read and forwards the returned data to that cache. A later unblock from the cache (unblkFromCache 1, unblkExcl 0) adds it to the sharers.
- R8: An unblock with unblkFromCache 0 leaves the sharer list unchanged.
- R9: A DMA write of either size to an owned line forwards the request to the owner (fwdValid, fwdOwner) and invalidates the sharers, with no memory request. The owner's data (ownerDataValid) is merged as in R4, written to memory and acknowledged. Ownership is then dropped.
- R10: reqReady is low in every transient state. A request presented while reqReady is low causes no memory request, invalidation, forward or response.
- R11: A cache read-exclusive request (reqKind 1) fetches the line and invalidates the other sharers. An exclusive unblock from the cache then makes that cache the owner, and later requests are forwarded to it.
- R12: After reset the line is invalid with no sharers and no owner, reqReady is high, and no output valid is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted in this cycle when high |
| reqKind | input | 2 | 0 cache read-shared, 1 cache read-exclusive, 2 DMA read, 3 DMA write |
| reqSrc | input | SRC_W | Requester identifier |
| reqOffset | input | OFF_W | Byte offset of a DMA write |
| reqLen | input | LEN_W | Byte count of a DMA write |
| reqData | input | 8*LINE_BYTES | DMA write bytes, lane i at bits 8i+7..8i |
| memReqValid | output | 1 | Memory request strobe |
| memReqWrite | output | 1 | 1 write, 0 read |
| memReqIsDma | output | 1 | Requester-type tag echoed by memory |
| memWrData | output | 8*LINE_BYTES | Line written to memory |
| memRspValid | input | 1 | Memory read data strobe |
| memRspIsDma | input | 1 | Echoed requester-type tag |
| memRspData | input | 8*LINE_BYTES | Memory read data |
| invValid | output | 1 | Invalidation strobe |
| invMask | output | NUM_CACHES | Caches to invalidate |
| fwdValid | output | 1 | Forward to owner strobe |
| fwdOwner | output | SRC_W | Owner cache identifier |
| ownerDataValid | input | 1 | Owner's line data strobe |
| ownerData | input | 8*LINE_BYTES | Owner's line data |
| rspValid | output | 1 | Response strobe |
| rspIsAck | output | 1 | 1 acknowledgement, 0 data |
| rspToDma | output | 1 | Response addressed to the DMA engine |
| rspDest | output | SRC_W | Destination identifier |
| rspAckCount | output | CNT_W | Invalidations the DMA engine must collect |
| rspData | output | 8*LINE_BYTES | Read data |
| unblkValid | input | 1 | Unblock strobe |
| unblkFromCache | input | 1 | Unblock sender is a cache |
| unblkExcl | input | 1 | Sender took the line exclusively |
| unblkSender | input | SRC_W | Unblock sender identifier |

## Verification
Partial writes are driven with random offsets and lengths against a known memory line. Because every byte of the written line is compared with a bench-computed merge, an off-by-one at either edge of the window shows up, as does a merge taken from the wrong base. Full-line writes are mixed into the same random stream so that a wrong length classification sends the transaction down the other path. Directed sequences build up sharers through cache reads, then a DMA write shows the sharer list through its invalidation mask and ack count. That mask separates a design that records DMA readers or DMA unblocks as sharers from one that does not. A line owned by a cache and then written by DMA separates merging against the owner's data from merging against memory, and a stalled request during a transient state shows whether anything leaks through the port.

// File: rtl/dir_dma_pkg.sv
package dir_dma_pkg;

  typedef enum logic [1:0] {
    K_RD_SHARED = 2'd0,
    K_RD_EXCL   = 2'd1,
    K_DMA_RD    = 2'd2,
    K_DMA_WR    = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_INV,
    ST_SHARED,
    ST_OWNED,
    ST_FETCH_RD,
    ST_FETCH_MERGE,
    ST_WAIT_OWNER,
    ST_WAIT_UNBLK
  } line_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureEntry;   // latch offset, length and bytes of a DMA write
    logic loadDirect;     // memory write data <= request bytes
    logic loadMergeMem;   // memory write data <= merge over memory line
    logic loadMergeOwner; // memory write data <= merge over owner line
    logic loadRspMem;     // response data <= memory line
  } dp_strobe_t;

endpackage

// File: rtl/dir_dma_datapath.sv
module dir_dma_datapath
  import dir_dma_pkg::*;
#(
  parameter int LINE_BYTES = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dp_strobe_t                strobe,
  input  logic [$clog2(LINE_BYTES)-1:0] reqOffset,
  input  logic [$clog2(LINE_BYTES):0]   reqLen,
  input  logic [8*LINE_BYTES-1:0]   reqData,
  input  logic [8*LINE_BYTES-1:0]   memRspData,
  input  logic [8*LINE_BYTES-1:0]   ownerData,
  output logic [8*LINE_BYTES-1:0]   memWrData,
  output logic [8*LINE_BYTES-1:0]   rspData
);

  localparam int LINE_BITS = 8 * LINE_BYTES;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int LEN_W     = OFF_W + 1;
  localparam int END_W     = LEN_W + 1;

  logic [OFF_W-1:0]     entOff;
  logic [LEN_W-1:0]     entLen;
  logic [LINE_BITS-1:0] entData;
  logic [LINE_BITS-1:0] mergeBase;
  logic [LINE_BITS-1:0] merged;
  logic [END_W-1:0]     entEnd;

  assign mergeBase = strobe.loadMergeOwner ? ownerData : memRspData;
  assign entEnd    = END_W'(entOff) + END_W'(entLen);

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    logic inWindow;
    assign inWindow = (END_W'(b) >= END_W'(entOff)) && (END_W'(b) < entEnd);
    assign merged[8*b +: 8] = inWindow ? entData[8*b +: 8] : mergeBase[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entOff    <= '0;
      entLen    <= '0;
      entData   <= '0;
      memWrData <= '0;
      rspData   <= '0;
    end else begin
      if (strobe.captureEntry) begin
        entOff  <= reqOffset;
        entLen  <= reqLen;
        entData <= reqData;
      end
      if (strobe.loadDirect) memWrData <= reqData;
      else if (strobe.loadMergeMem || strobe.loadMergeOwner) memWrData <= merged;
      if (strobe.loadRspMem) rspData <= memRspData;
    end
  end

endmodule

// File: rtl/dir_dma_ctrl.sv
module dir_dma_ctrl
  import dir_dma_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int NUM_CACHES = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            reqValid,
  input  logic [1:0]                      reqKind,
  input  logic [$clog2(NUM_CACHES)-1:0]   reqSrc,
  input  logic [$clog2(LINE_BYTES):0]     reqLen,
  output logic                            reqReady,
  input  logic                            memRspValid,
  input  logic                            memRspIsDma,
  input  logic                            ownerDataValid,
  input  logic                            unblkValid,
  input  logic                            unblkFromCache,
  input  logic                            unblkExcl,
  input  logic [$clog2(NUM_CACHES)-1:0]   unblkSender,
  output dp_strobe_t                      strobe,
  output logic                            memReqValid,
  output logic                            memReqWrite,
  output logic                            memReqIsDma,
  output logic                            invValid,
  output logic [NUM_CACHES-1:0]           invMask,
  output logic                            fwdValid,
  output logic [$clog2(NUM_CACHES)-1:0]   fwdOwner,
  output logic                            rspValid,
  output logic                            rspIsAck,
  output logic                            rspToDma,
  output logic [$clog2(NUM_CACHES)-1:0]   rspDest,
  output logic [$clog2(NUM_CACHES+1)-1:0] rspAckCount,
  output line_state_e                     lineState,
  output logic [NUM_CACHES-1:0]           sharerMask
);

  localparam int SRC_W = $clog2(NUM_CACHES);
  localparam int CNT_W = $clog2(NUM_CACHES + 1);
  localparam int LEN_W = $clog2(LINE_BYTES) + 1;

  function automatic logic [CNT_W-1:0] countOnes(input logic [NUM_CACHES-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NUM_CACHES; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  line_state_e           state, nState;
  logic [NUM_CACHES-1:0] sharers, nSharers;
  logic [SRC_W-1:0]      owner, nOwner, reqId, nReqId;
  logic                  ownerV, nOwnerV, injPending, nInj;
  logic [CNT_W-1:0]      ackCnt, nAck;

  logic                  nMemV, nMemWr, nMemDma, nInvV, nFwdV;
  logic                  nRspV, nRspAck, nRspDma;
  logic [NUM_CACHES-1:0] nInvMask, srcBit, senderBit;
  logic [SRC_W-1:0]      nFwdOwner, nRspDest;
  logic [CNT_W-1:0]      nRspCnt;

  req_kind_e kind;
  logic      stable, accept, isFull, fromCache;

  assign kind       = req_kind_e'(reqKind);
  assign stable     = (state == ST_INV) || (state == ST_SHARED) || (state == ST_OWNED);
  assign reqReady   = stable;
  assign accept     = reqValid && stable;
  assign isFull     = (reqLen == LEN_W'(LINE_BYTES));
  assign lineState  = state;
  assign sharerMask = sharers;

  always_comb begin
    srcBit    = '0;
    srcBit[reqSrc] = 1'b1;
    senderBit = '0;
    senderBit[unblkSender] = 1'b1;
    fromCache = 1'b0;

    nState = state;   nSharers = sharers; nOwner = owner; nOwnerV = ownerV;
    nReqId = reqId;   nAck = ackCnt;      nInj = injPending;
    nMemV = 1'b0; nMemWr = 1'b0; nMemDma = 1'b0;
    nInvV = 1'b0; nInvMask = '0;
    nFwdV = 1'b0; nFwdOwner = owner;
    nRspV = 1'b0; nRspAck = 1'b0; nRspDma = 1'b0; nRspDest = reqId; nRspCnt = '0;
    strobe = '0;

    unique case (state)
      ST_INV, ST_SHARED: if (accept) begin
        nReqId = reqSrc;
        unique case (kind)
          K_RD_SHARED, K_DMA_RD: begin
            nMemV   = 1'b1;
            nMemDma = (kind == K_DMA_RD);
            nState  = ST_FETCH_RD;
          end
          K_RD_EXCL: begin
            nInvMask = sharers & ~srcBit;
            nInvV    = |nInvMask;
            nSharers = '0;
            nMemV    = 1'b1;
            nState   = ST_FETCH_RD;
          end
          K_DMA_WR: begin
            nInvV    = |sharers;
            nInvMask = sharers;
            nSharers = '0;
            strobe.captureEntry = 1'b1;
            nMemV   = 1'b1;
            nMemDma = 1'b1;
            if (isFull) begin
              nMemWr  = 1'b1;
              strobe.loadDirect = 1'b1;
              nRspV   = 1'b1;
              nRspAck = 1'b1;
              nRspDma = 1'b1;
              nRspDest = reqSrc;
              nRspCnt = countOnes(sharers);
              nState  = ST_WAIT_UNBLK;
            end else begin
              nAck   = countOnes(sharers);
              nState = ST_FETCH_MERGE;
            end
          end
          default: ;
        endcase
      end
      ST_OWNED: if (accept) begin
        nReqId = reqSrc;
        nFwdV  = 1'b1;
        nState = ST_WAIT_UNBLK;
        if (kind == K_RD_EXCL) begin
          nInvMask = sharers & ~srcBit;
          nInvV    = |nInvMask;
          nSharers = '0;
        end else if (kind == K_DMA_WR) begin
          nInvV    = |sharers;
          nInvMask = sharers;
          nSharers = '0;
          nAck     = countOnes(sharers);
          strobe.captureEntry = 1'b1;
          nState   = ST_WAIT_OWNER;
        end
      end
      ST_FETCH_RD: if (memRspValid) begin
        nRspV   = 1'b1;
        nRspDma = memRspIsDma;
        strobe.loadRspMem = 1'b1;
        nInj    = memRspIsDma;
        nState  = ST_WAIT_UNBLK;
      end
      ST_FETCH_MERGE: if (memRspValid) begin
        strobe.loadMergeMem = 1'b1;
        nMemV = 1'b1; nMemWr = 1'b1; nMemDma = 1'b1;
        nRspV = 1'b1; nRspAck = 1'b1; nRspDma = 1'b1; nRspCnt = ackCnt;
        nState = ST_WAIT_UNBLK;
      end
      ST_WAIT_OWNER: if (ownerDataValid) begin
        strobe.loadMergeOwner = 1'b1;
        nMemV = 1'b1; nMemWr = 1'b1; nMemDma = 1'b1;
        nRspV = 1'b1; nRspAck = 1'b1; nRspDma = 1'b1; nRspCnt = ackCnt;
        nOwnerV = 1'b0;
        nState  = ST_WAIT_UNBLK;
      end
      ST_WAIT_UNBLK: if (injPending || unblkValid) begin
        fromCache = !injPending && unblkFromCache;
        if (fromCache && unblkExcl) begin
          nOwner   = unblkSender;
          nOwnerV  = 1'b1;
          nSharers = '0;
        end else if (fromCache) begin
          nSharers = sharers | senderBit;
        end
        nInj   = 1'b0;
        nState = nOwnerV ? ST_OWNED : ((|nSharers) ? ST_SHARED : ST_INV);
      end
      default: nState = ST_INV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_INV; sharers <= '0; owner <= '0; ownerV <= 1'b0;
      reqId <= '0; ackCnt <= '0; injPending <= 1'b0;
      memReqValid <= 1'b0; memReqWrite <= 1'b0; memReqIsDma <= 1'b0;
      invValid <= 1'b0; invMask <= '0; fwdValid <= 1'b0; fwdOwner <= '0;
      rspValid <= 1'b0; rspIsAck <= 1'b0; rspToDma <= 1'b0;
      rspDest <= '0; rspAckCount <= '0;
    end else begin
      state <= nState; sharers <= nSharers; owner <= nOwner; ownerV <= nOwnerV;
      reqId <= nReqId; ackCnt <= nAck; injPending <= nInj;
      memReqValid <= nMemV; memReqWrite <= nMemWr; memReqIsDma <= nMemDma;
      invValid <= nInvV; invMask <= nInvMask; fwdValid <= nFwdV; fwdOwner <= nFwdOwner;
      rspValid <= nRspV; rspIsAck <= nRspAck; rspToDma <= nRspDma;
      rspDest <= nRspDest; rspAckCount <= nRspCnt;
    end
  end

endmodule

// File: rtl/dir_dma_slice.sv
module dir_dma_slice
  import dir_dma_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int NUM_CACHES = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            reqValid,
  output logic                            reqReady,
  input  logic [1:0]                      reqKind,
  input  logic [$clog2(NUM_CACHES)-1:0]   reqSrc,
  input  logic [$clog2(LINE_BYTES)-1:0]   reqOffset,
  input  logic [$clog2(LINE_BYTES):0]     reqLen,
  input  logic [8*LINE_BYTES-1:0]         reqData,
  output logic                            memReqValid,
  output logic                            memReqWrite,
  output logic                            memReqIsDma,
  output logic [8*LINE_BYTES-1:0]         memWrData,
  input  logic                            memRspValid,
  input  logic                            memRspIsDma,
  input  logic [8*LINE_BYTES-1:0]         memRspData,
  output logic                            invValid,
  output logic [NUM_CACHES-1:0]           invMask,
  output logic                            fwdValid,
  output logic [$clog2(NUM_CACHES)-1:0]   fwdOwner,
  input  logic                            ownerDataValid,
  input  logic [8*LINE_BYTES-1:0]         ownerData,
  output logic                            rspValid,
  output logic                            rspIsAck,
  output logic                            rspToDma,
  output logic [$clog2(NUM_CACHES)-1:0]   rspDest,
  output logic [$clog2(NUM_CACHES+1)-1:0] rspAckCount,
  output logic [8*LINE_BYTES-1:0]         rspData,
  input  logic                            unblkValid,
  input  logic                            unblkFromCache,
  input  logic                            unblkExcl,
  input  logic [$clog2(NUM_CACHES)-1:0]   unblkSender
);

  dp_strobe_t            strobe;
  line_state_e           lineState;
  logic [NUM_CACHES-1:0] sharerMask;

  dir_dma_ctrl #(.LINE_BYTES(LINE_BYTES), .NUM_CACHES(NUM_CACHES)) ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqKind(reqKind), .reqSrc(reqSrc), .reqLen(reqLen),
    .reqReady(reqReady),
    .memRspValid(memRspValid), .memRspIsDma(memRspIsDma),
    .ownerDataValid(ownerDataValid),
    .unblkValid(unblkValid), .unblkFromCache(unblkFromCache),
    .unblkExcl(unblkExcl), .unblkSender(unblkSender),
    .strobe(strobe),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqIsDma(memReqIsDma),
    .invValid(invValid), .invMask(invMask),
    .fwdValid(fwdValid), .fwdOwner(fwdOwner),
    .rspValid(rspValid), .rspIsAck(rspIsAck), .rspToDma(rspToDma),
    .rspDest(rspDest), .rspAckCount(rspAckCount),
    .lineState(lineState), .sharerMask(sharerMask)
  );

  dir_dma_datapath #(.LINE_BYTES(LINE_BYTES)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqOffset(reqOffset), .reqLen(reqLen), .reqData(reqData),
    .memRspData(memRspData), .ownerData(ownerData),
    .memWrData(memWrData), .rspData(rspData)
  );

endmodule

// File: rtl/dir_dma_slice_chk.sv
module dir_dma_slice_chk
  import dir_dma_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int NUM_CACHES = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          reqValid,
  input logic                          reqReady,
  input logic [1:0]                    reqKind,
  input logic [$clog2(LINE_BYTES)-1:0] reqOffset,
  input logic [$clog2(LINE_BYTES):0]   reqLen,
  input logic                          memReqValid,
  input logic                          memReqWrite,
  input logic                          memReqIsDma,
  input logic                          memRspValid,
  input logic                          memRspIsDma,
  input logic                          invValid,
  input logic                          fwdValid,
  input logic                          ownerDataValid,
  input logic                          rspValid,
  input logic                          rspIsAck,
  input logic                          rspToDma,
  input logic                          unblkValid,
  input logic                          unblkFromCache,
  input line_state_e                   lineState,
  input logic [NUM_CACHES-1:0]         sharerMask
);

  localparam int LEN_W = $clog2(LINE_BYTES) + 1;

  logic wrAccept, wrFull;
  assign wrAccept = reqValid && reqReady && (reqKind == 2'd3);
  assign wrFull   = (reqLen == LEN_W'(LINE_BYTES));

  // R1: a full-line write arrives line-aligned
  a_r1_full_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 2'd3 && wrFull) |-> (reqOffset == '0));

  // R2: full write to a non-owned line -> memory write plus ack next cycle
  a_r2_full_write_ack: assert property (@(posedge clk) disable iff (!rstN)
    (wrAccept && wrFull && lineState != ST_OWNED) |=>
      (memReqValid && memReqWrite && rspValid && rspIsAck && rspToDma));

  // R3: partial write to a non-owned line -> DMA-tagged fetch, no response
  a_r3_partial_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (wrAccept && !wrFull && lineState != ST_OWNED) |=>
      (memReqValid && !memReqWrite && memReqIsDma && !rspValid));

  // R4: merge data returned -> write back and ack next cycle
  a_r4_merge_writeback: assert property (@(posedge clk) disable iff (!rstN)
    (lineState == ST_FETCH_MERGE && memRspValid) |=>
      (memReqValid && memReqWrite && rspValid && rspIsAck));

  // R5: write to a shared line invalidates and empties the sharer list
  a_r5_shared_inval: assert property (@(posedge clk) disable iff (!rstN)
    (wrAccept && lineState == ST_SHARED) |=> (invValid && sharerMask == '0));

  // R6: DMA-tagged read data is delivered to the DMA engine
  a_r6_dma_read_route: assert property (@(posedge clk) disable iff (!rstN)
    (lineState == ST_FETCH_RD && memRspValid && memRspIsDma) |=>
      (rspValid && !rspIsAck && rspToDma));

  // R8: an unblock from the DMA engine leaves the sharers alone
  a_r8_dma_unblock_no_sharer: assert property (@(posedge clk) disable iff (!rstN)
    (lineState == ST_WAIT_UNBLK && unblkValid && !unblkFromCache) |=> $stable(sharerMask));

  // R9: write to an owned line goes to the owner, not to memory
  a_r9_owned_forward: assert property (@(posedge clk) disable iff (!rstN)
    (wrAccept && lineState == ST_OWNED) |=> (fwdValid && !memReqValid));

  // R10: a stalled request produces nothing
  a_r10_stall_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady && !memRspValid && !ownerDataValid && !unblkValid) |=>
      (!memReqValid && !invValid && !fwdValid && !rspValid));

endmodule

bind dir_dma_slice dir_dma_slice_chk #(.LINE_BYTES(LINE_BYTES), .NUM_CACHES(NUM_CACHES)) chkInst (.*);

// File: tb/dir_dma_slice_test.sv
module dir_dma_slice_test;

  localparam int LINE_BYTES = 16;
  localparam int NUM_CACHES = 4;
  localparam int LINE_BITS  = 8 * LINE_BYTES;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int LEN_W      = OFF_W + 1;
  localparam int SRC_W      = $clog2(NUM_CACHES);
  localparam int CNT_W      = $clog2(NUM_CACHES + 1);
  localparam logic [SRC_W-1:0] DMA_ID = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [1:0] reqKind = '0;
  logic [SRC_W-1:0] reqSrc = '0;
  logic [OFF_W-1:0] reqOffset = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [LINE_BITS-1:0] reqData = '0;
  logic memReqValid, memReqWrite, memReqIsDma;
  logic [LINE_BITS-1:0] memWrData;
  logic memRspValid = 1'b0, memRspIsDma = 1'b0;
  logic [LINE_BITS-1:0] memRspData = '0;
  logic invValid;
  logic [NUM_CACHES-1:0] invMask;
  logic fwdValid;
  logic [SRC_W-1:0] fwdOwner;
  logic ownerDataValid = 1'b0;
  logic [LINE_BITS-1:0] ownerData = '0;
  logic rspValid, rspIsAck, rspToDma;
  logic [SRC_W-1:0] rspDest;
  logic [CNT_W-1:0] rspAckCount;
  logic [LINE_BITS-1:0] rspData;
  logic unblkValid = 1'b0, unblkFromCache = 1'b0, unblkExcl = 1'b0;
  logic [SRC_W-1:0] unblkSender = '0;

  int total = 0;
  int fails = 0;
  logic [LINE_BITS-1:0] memLine;

  always #4 clk = ~clk;

  dir_dma_slice #(.LINE_BYTES(LINE_BYTES), .NUM_CACHES(NUM_CACHES)) uut (.*);

  task automatic chk(input string tag, input logic [LINE_BITS-1:0] act,
                     input logic [LINE_BITS-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [LINE_BITS-1:0] mergeRef(
      input logic [LINE_BITS-1:0] base, input logic [LINE_BITS-1:0] data,
      input int off, input int len);
    logic [LINE_BITS-1:0] r;
    r = base;
    for (int b = 0; b < LINE_BYTES; b++)
      if (b >= off && b < off + len) r[8*b +: 8] = data[8*b +: 8];
    return r;
  endfunction

  function automatic logic [LINE_BITS-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // every task starts and ends at a falling edge
  task automatic issue(input int kind, input int src, input int off, input int len,
                       input logic [LINE_BITS-1:0] data);
    reqValid = 1'b1; reqKind = 2'(kind); reqSrc = SRC_W'(src);
    reqOffset = OFF_W'(off); reqLen = LEN_W'(len); reqData = data;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic memReply(input logic [LINE_BITS-1:0] data, input logic tag);
    memRspValid = 1'b1; memRspData = data; memRspIsDma = tag;
    @(negedge clk);
    memRspValid = 1'b0;
  endtask

  task automatic unblock(input logic fromCache, input logic excl, input int sender);
    unblkValid = 1'b1; unblkFromCache = fromCache; unblkExcl = excl;
    unblkSender = SRC_W'(sender);
    @(negedge clk);
    unblkValid = 1'b0;
  endtask

  task automatic cacheReadShared(input int id);
    issue(0, id, 0, 0, '0);
    chk("R7 cache read fetch", {memReqValid, memReqWrite, memReqIsDma}, 3'b100);
    memReply(memLine, 1'b0);
    chk("R7 data to cache", {rspValid, rspIsAck, rspToDma}, 3'b100);
    chk("R7 data dest", rspDest, id);
    chk("R7 data value", rspData, memLine);
    unblock(1'b1, 1'b0, id);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : stimulus
    logic [LINE_BITS-1:0] d, exp;
    void'($urandom(32'h5eed));
    memLine = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 ready after reset", reqReady, 1'b1);
    chk("R12 no outputs", {memReqValid, invValid, fwdValid, rspValid}, 4'b0);

    // R2 full write into an invalid line
    d = rnd128();
    issue(3, DMA_ID, 0, LINE_BYTES, d);
    chk("R2 memory write", {memReqValid, memReqWrite}, 2'b11);
    chk("R2 write data", memWrData, d);
    chk("R2 ack", {rspValid, rspIsAck, rspToDma, invValid}, 4'b1110);
    chk("R2 ack count zero", rspAckCount, 0);
    chk("R10 busy while waiting", reqReady, 1'b0);
    memLine = d;
    issue(2, DMA_ID, 0, 0, '0);   // presented while stalled
    chk("R10 stalled request silent", {memReqValid, invValid, fwdValid, rspValid}, 4'b0);
    unblock(1'b0, 1'b0, DMA_ID);
    chk("R2 ready after unblock", reqReady, 1'b1);

    // R7 two caches become sharers
    cacheReadShared(1);
    cacheReadShared(2);

    // R6 DMA read of a shared line
    issue(2, DMA_ID, 0, 0, '0);
    chk("R6 DMA tagged fetch", {memReqValid, memReqWrite, memReqIsDma}, 3'b101);
    memReply(memLine, 1'b1);
    chk("R6 data to DMA", {rspValid, rspIsAck, rspToDma}, 3'b101);
    chk("R6 data value", rspData, memLine);
    @(negedge clk);
    chk("R6 internal unblock releases line", reqReady, 1'b1);

    // R3 R4 R5 partial write into the shared line
    d = rnd128();
    issue(3, DMA_ID, 5, 3, d);
    chk("R5 R6 invalidate exactly caches 1,2", {invValid, invMask}, 5'b10110);
    chk("R3 fetch tagged DMA", {memReqValid, memReqWrite, memReqIsDma}, 3'b101);
    chk("R3 no response yet", rspValid, 1'b0);
    memReply(memLine, 1'b1);
    exp = mergeRef(memLine, d, 5, 3);
    chk("R4 merged write", {memReqValid, memReqWrite}, 2'b11);
    chk("R4 merged line", memWrData, exp);
    chk("R4 untouched low bytes", memWrData[39:0], memLine[39:0]);
    chk("R4 untouched high bytes", memWrData[LINE_BITS-1:64], memLine[LINE_BITS-1:64]);
    chk("R5 ack count equals sharers", {rspValid, rspIsAck, 3'(rspAckCount)}, 5'b11010);
    memLine = exp;
    unblock(1'b0, 1'b0, DMA_ID);

    // R5 sharers gone afterwards
    d = rnd128();
    issue(3, DMA_ID, 0, LINE_BYTES, d);
    chk("R5 sharers cleared", {invValid, 3'(rspAckCount)}, 4'b0);
    memLine = d;
    unblock(1'b0, 1'b0, DMA_ID);

    // R8 DMA unblock ends a cache read without adding any sharer
    issue(0, 0, 0, 0, '0);
    memReply(memLine, 1'b0);
    unblock(1'b0, 1'b0, 0);
    chk("R8 line released", reqReady, 1'b1);
    d = rnd128();
    issue(3, DMA_ID, 0, LINE_BYTES, d);
    chk("R8 no sharer recorded", {invValid, 3'(rspAckCount)}, 4'b0);
    memLine = d;
    unblock(1'b0, 1'b0, DMA_ID);

    // R1 R4 random mix of partial and full writes
    for (int i = 0; i < 24; i++) begin
      int off, len;
      off = int'($urandom % LINE_BYTES);
      len = 1 + int'($urandom % (LINE_BYTES - off));
      d = rnd128();
      issue(3, DMA_ID, off, len, d);
      if (len == LINE_BYTES) begin
        chk("R1 full write goes direct", {memReqValid, memReqWrite, rspValid}, 3'b111);
        chk("R1 full data", memWrData, d);
        memLine = d;
      end else begin
        chk("R1 partial write fetches", {memReqValid, memReqWrite, rspValid}, 3'b100);
        memReply(memLine, 1'b1);
        exp = mergeRef(memLine, d, off, len);
        chk("R4 random merge", memWrData, exp);
        chk("R4 random ack", {rspValid, rspIsAck, rspToDma}, 3'b111);
        memLine = exp;
      end
      unblock(1'b0, 1'b0, DMA_ID);
    end

    // R11 cache 2 takes the line exclusively
    issue(1, 2, 0, 0, '0);
    chk("R11 exclusive fetch", {memReqValid, memReqWrite, memReqIsDma, invValid}, 4'b1000);
    memReply(memLine, 1'b0);
    chk("R11 data to cache 2", {rspValid, rspToDma, 2'(rspDest)}, 4'b1010);
    unblock(1'b1, 1'b1, 2);
    issue(0, 1, 0, 0, '0);
    chk("R11 read forwarded to owner", {fwdValid, 2'(fwdOwner), memReqValid}, 4'b1100);
    unblock(1'b1, 1'b0, 1);

    // R9 partial DMA write into the owned line
    d = rnd128();
    issue(3, DMA_ID, 10, 4, d);
    chk("R9 forward to owner", {fwdValid, 2'(fwdOwner), memReqValid}, 4'b1100);
    chk("R9 invalidate sharer 1", {invValid, invMask}, 5'b10010);
    ownerData = rnd128();
    ownerDataValid = 1'b1;
    @(negedge clk);
    ownerDataValid = 1'b0;
    exp = mergeRef(ownerData, d, 10, 4);
    chk("R9 merge over owner data", memWrData, exp);
    chk("R9 write and ack", {memReqValid, memReqWrite, rspValid, rspIsAck, 3'(rspAckCount)}, 7'b1111001);
    memLine = exp;
    unblock(1'b0, 1'b0, DMA_ID);
    issue(2, DMA_ID, 0, 0, '0);
    chk("R9 ownership dropped", {fwdValid, memReqValid}, 2'b01);
    memReply(memLine, 1'b1);
    chk("R9 written line read back", rspData, exp);
    @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule